// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block collects a small set of pending event flags, gates them through an enable mask and drives a single active-low interrupt line toward a host. Two sources raise events. The first is a free-running one-second tick, counted in clock cycles. The second is a peripheral-input path that reports a ready reply, either directly or as the result of a background poll. The reply bytes themselves sit in an external reply buffer, which the block reads through a simple address/data port.

The host talks to the block through two commands presented on a command port. One command loads the enable mask. The other acknowledges pending events. The acknowledge returns a byte stream, and its shape depends on whether the input-device event is pending. If it is pending, the stream is a header holding only the input-device and poll flags, followed by the buffered reply bytes, and only those two flags are cleared. If it is not pending, the stream is a single byte holding every pending flag, and everything is cleared. The block receives command bytes already framed and does not model the peripheral bus.

The reply stream comes from a three-state machine:
- ST_IDLE accepts commands and events.
- ST_HEAD emits the first reply byte.
- ST_BODY emits the buffered bytes.

The transitions are:
- IDLE→HEAD on a valid acknowledge.
- HEAD→IDLE when no buffered bytes follow.
- HEAD→BODY when buffered bytes follow.
- BODY→BODY while bytes remain.
- BODY→IDLE after the last byte.

Top module: `evt_irq_hub`

## Requirements
- R1: `irq_n` is 0 whenever (pending AND mask) is nonzero and 1 otherwise. It follows the registered pending and mask values, so it changes in the cycle after the edge that changes either of them.
- R2: After reset the pending flags are 0, `irq_n` is 1 and `cmd_ready` is 1. The mask enables exactly the input-device bit (bit 4, 0x10) and the tick bit (bit 5, 0x20), so the reset mask is 0x30. The poll flag is bit 7 (0x80).
- R3: The tick flag is set on edge number k·TICK_CYCLES after reset release, for every k ≥ 1. It comes from a free-running counter that commands never adjust, so it does not drift.
- R4: A command with `cmd_op`=0 (set mask) and `cmd_argc`=1 loads `cmd_arg` into the mask. With any other argument count, the mask is unchanged and no reply is produced.
- R5: A command with `cmd_op`=1 (acknowledge) is accepted only with `cmd_argc`=0. With any other argument count, there is no reply and the pending flags are unchanged. No reply byte appears without an accepted acknowledge.
- R6: An acknowledge while bit 4 is pending works as follows:
  - The first byte is pending AND 0x90.
  - It is followed by the stored reply size in bytes, read from `rbuf_addr` 0, 1, 2 and so on.
  - `rsp_last` marks the final byte.
  - Bits 4 and 7 are cleared, and the stored size becomes 0.
- R7: An acknowledge while bit 4 is clear returns a single byte holding all pending flags, with `rsp_last` set, and clears all flags.
- R8: A poll result is taken only in ST_IDLE, with bit 4 clear, a nonzero length, and no direct reply in the same cycle. When taken, it sets bits 4 and 7 and stores the length. Otherwise it is ignored.
- R9: A direct reply-ready input in ST_IDLE sets bit 4 only and stores its length. It wins over a poll result in the same cycle.
- R10: The following ordering rules hold:
  - An event raised on the same edge that an acknowledge clears the flags survives the clear.
  - `cmd_ready` is 0 while a reply streams.
  - Commands and reply-ready inputs presented while a reply streams are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 1 | 0 = set mask, 1 = acknowledge |
| cmd_argc | input | ARGC_W | Argument byte count of the command |
| cmd_arg | input | EVT_W | First argument byte |
| cmd_ready | output | 1 | Block is in ST_IDLE and takes a command |
| dev_reply_valid | input | 1 | Direct input-device reply ready (pulse) |
| dev_reply_len | input | SIZE_W | Byte count of that reply (≤ REPLY_DEPTH) |
| poll_valid | input | 1 | Poll result ready (pulse) |
| poll_len | input | SIZE_W | Byte count of the poll result (≤ REPLY_DEPTH) |
| rbuf_addr | output | ADDR_W | Reply buffer read address |
| rbuf_data | input | EVT_W | Reply buffer byte at `rbuf_addr` (combinational) |
| rsp_valid | output | 1 | Reply byte valid this cycle |
| rsp_data | output | EVT_W | Reply byte |
| rsp_last | output | 1 | Final byte of the reply |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest situations to reach from the ports are a tick landing on the exact edge where an acknowledge clears the flags, and a poll result arriving while the input-device flag is still pending. The first needs cycle alignment with a hidden counter. The second needs the buffer to keep its earlier contents even though a new result was offered. The bench tracks the tick phase in its own model and issues the acknowledge on the edge the tick fires. It stacks a direct reply, a rejected poll and a zero-length poll before acknowledging, so that each reply byte shows which event won. Constrained random traffic then mixes both commands, malformed argument counts and overlapping events against the same model.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } rsp_state_e;

    localparam logic OP_SET_MASK = 1'b0;
    localparam logic OP_ACK      = 1'b1;

endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
    parameter int unsigned PERIOD = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3

endmodule

// File: rtl/evt_pend_reg.sv
module evt_pend_reg #(
    parameter int unsigned EVT_W       = 8,
    parameter int unsigned REPLY_DEPTH = 8,
    parameter int unsigned DEV_BIT     = 4,
    parameter int unsigned AUTO_BIT    = 7,
    parameter int unsigned TICK_BIT    = 5,
    localparam int unsigned SIZE_W     = $clog2(REPLY_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              idle_i,
    input  logic              dev_set_i,
    input  logic [SIZE_W-1:0] dev_len_i,
    input  logic              poll_i,
    input  logic [SIZE_W-1:0] poll_len_i,
    input  logic [EVT_W-1:0]  clr_bits_i,
    input  logic              clr_size_i,
    input  logic              mask_ld_i,
    input  logic [EVT_W-1:0]  mask_val_i,
    output logic [EVT_W-1:0]  pend_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              irq_n_o
);
    localparam logic [EVT_W-1:0] MASK_RST = EVT_W'((1 << DEV_BIT) | (1 << TICK_BIT));

    logic [EVT_W-1:0]  pend_q;
    logic [EVT_W-1:0]  mask_q;
    logic [SIZE_W-1:0] size_q;
    logic [EVT_W-1:0]  set_bits;
    logic              dev_take;
    logic              poll_take;

    assign dev_take  = idle_i && dev_set_i;
    assign poll_take = idle_i && poll_i && !dev_set_i && !pend_q[DEV_BIT]
                       && (poll_len_i != '0);

    for (genvar b = 0; b < EVT_W; b++) begin : g_set
        assign set_bits[b] = ((b == TICK_BIT) && tick_i)
                           | ((b == DEV_BIT)  && (dev_take || poll_take))
                           | ((b == AUTO_BIT) && poll_take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= MASK_RST;
            size_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_bits_i) | set_bits;
            if (mask_ld_i) begin
                mask_q <= mask_val_i;
            end
            if (dev_take) begin
                size_q <= dev_len_i;
            end else if (poll_take) begin
                size_q <= poll_len_i;
            end else if (clr_size_i) begin
                size_q <= '0;
            end
        end
    end

    assign pend_o  = pend_q;
    assign size_o  = size_q;
    assign irq_n_o = ~|(pend_q & mask_q);

    AST_TICK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> pend_q[TICK_BIT]); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_ld_i |=> $stable(mask_q)); // R4
    AST_POLL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && pend_q[DEV_BIT] && !dev_set_i && !clr_size_i) |=> $stable(size_q)); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_n_o) |-> (!$stable(pend_q) || !$stable(mask_q))); // R1
    AST_STREAM_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> $stable(size_q)); // R10

endmodule

// File: rtl/evt_ack_fsm.sv
module evt_ack_fsm
    import evt_irq_pkg::*;
#(
    parameter int unsigned EVT_W       = 8,
    parameter int unsigned REPLY_DEPTH = 8,
    parameter int unsigned ARGC_W      = 4,
    parameter int unsigned DEV_BIT     = 4,
    parameter int unsigned AUTO_BIT    = 7,
    localparam int unsigned SIZE_W     = $clog2(REPLY_DEPTH + 1),
    localparam int unsigned ADDR_W     = (REPLY_DEPTH > 1) ? $clog2(REPLY_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic              cmd_op_i,
    input  logic [ARGC_W-1:0] cmd_argc_i,
    input  logic [EVT_W-1:0]  cmd_arg_i,
    input  logic [EVT_W-1:0]  pend_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [EVT_W-1:0]  rbuf_data_i,
    output logic              cmd_ready_o,
    output logic              idle_o,
    output logic              mask_ld_o,
    output logic [EVT_W-1:0]  mask_val_o,
    output logic [EVT_W-1:0]  clr_bits_o,
    output logic              clr_size_o,
    output logic              rsp_valid_o,
    output logic [EVT_W-1:0]  rsp_data_o,
    output logic              rsp_last_o,
    output logic [ADDR_W-1:0] rbuf_addr_o
);
    localparam logic [EVT_W-1:0] DEV_PAIR = EVT_W'((1 << DEV_BIT) | (1 << AUTO_BIT));

    rsp_state_e        state_q, state_d;
    logic [EVT_W-1:0]  hdr_q;
    logic [SIZE_W-1:0] cnt_q;
    logic [ADDR_W-1:0] idx_q;
    logic              take;
    logic              ack_ok;
    logic              dev_path;
    logic              body_last;

    assign take      = cmd_valid_i && (state_q == ST_IDLE);
    assign ack_ok    = take && (cmd_op_i == OP_ACK) && (cmd_argc_i == ARGC_W'(0));
    assign dev_path  = pend_i[DEV_BIT];
    assign body_last = ((SIZE_W'(idx_q) + 1'b1) == cnt_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ack_ok) state_d = ST_HEAD;
            ST_HEAD: state_d = (cnt_q == '0) ? ST_IDLE : ST_BODY;
            ST_BODY: if (body_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // reply header, body length and read index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            cnt_q <= '0;
            idx_q <= '0;
        end else if (ack_ok) begin
            hdr_q <= dev_path ? (pend_i & DEV_PAIR) : pend_i;
            cnt_q <= dev_path ? size_i : '0;
            idx_q <= '0;
        end else if (state_q == ST_BODY) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd_ready_o = 1'b0;
        idle_o      = 1'b0;
        mask_ld_o   = 1'b0;
        mask_val_o  = cmd_arg_i;
        clr_bits_o  = '0;
        clr_size_o  = 1'b0;
        rsp_valid_o = 1'b0;
        rsp_data_o  = '0;
        rsp_last_o  = 1'b0;
        rbuf_addr_o = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready_o = 1'b1;
                idle_o      = 1'b1;
                mask_ld_o   = take && (cmd_op_i == OP_SET_MASK)
                              && (cmd_argc_i == ARGC_W'(1));
                if (ack_ok) begin
                    clr_bits_o = dev_path ? DEV_PAIR : '1;
                    clr_size_o = dev_path;
                end
            end
            ST_HEAD: begin
                rsp_valid_o = 1'b1;
                rsp_data_o  = hdr_q;
                rsp_last_o  = (cnt_q == '0);
            end
            ST_BODY: begin
                rsp_valid_o = 1'b1;
                rsp_data_o  = rbuf_data_i;
                rsp_last_o  = body_last;
            end
            default: ;
        endcase
    end

    AST_HEAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEAD) |=> (state_q != ST_HEAD)); // R6
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_last_o) |=> !rsp_valid_o); // R6
    AST_NO_STRAY_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !ack_ok) |=> !rsp_valid_o); // R5

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub #(
    parameter int unsigned EVT_W       = 8,
    parameter int unsigned REPLY_DEPTH = 8,
    parameter int unsigned ARGC_W      = 4,
    parameter int unsigned DEV_BIT     = 4,
    parameter int unsigned AUTO_BIT    = 7,
    parameter int unsigned TICK_BIT    = 5,
    parameter int unsigned TICK_CYCLES = 100_000_000,
    localparam int unsigned SIZE_W     = $clog2(REPLY_DEPTH + 1),
    localparam int unsigned ADDR_W     = (REPLY_DEPTH > 1) ? $clog2(REPLY_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ARGC_W-1:0] cmd_argc,
    input  logic [EVT_W-1:0]  cmd_arg,
    output logic              cmd_ready,
    input  logic              dev_reply_valid,
    input  logic [SIZE_W-1:0] dev_reply_len,
    input  logic              poll_valid,
    input  logic [SIZE_W-1:0] poll_len,
    output logic [ADDR_W-1:0] rbuf_addr,
    input  logic [EVT_W-1:0]  rbuf_data,
    output logic              rsp_valid,
    output logic [EVT_W-1:0]  rsp_data,
    output logic              rsp_last,
    output logic              irq_n
);
    logic              tick;
    logic              idle;
    logic              mask_ld;
    logic [EVT_W-1:0]  mask_val;
    logic [EVT_W-1:0]  clr_bits;
    logic              clr_size;
    logic [EVT_W-1:0]  pend;
    logic [SIZE_W-1:0] size;

    evt_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    evt_pend_reg #(
        .EVT_W(EVT_W), .REPLY_DEPTH(REPLY_DEPTH),
        .DEV_BIT(DEV_BIT), .AUTO_BIT(AUTO_BIT), .TICK_BIT(TICK_BIT)
    ) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .idle_i     (idle),
        .dev_set_i  (dev_reply_valid),
        .dev_len_i  (dev_reply_len),
        .poll_i     (poll_valid),
        .poll_len_i (poll_len),
        .clr_bits_i (clr_bits),
        .clr_size_i (clr_size),
        .mask_ld_i  (mask_ld),
        .mask_val_i (mask_val),
        .pend_o     (pend),
        .size_o     (size),
        .irq_n_o    (irq_n)
    );

    evt_ack_fsm #(
        .EVT_W(EVT_W), .REPLY_DEPTH(REPLY_DEPTH), .ARGC_W(ARGC_W),
        .DEV_BIT(DEV_BIT), .AUTO_BIT(AUTO_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_argc_i  (cmd_argc),
        .cmd_arg_i   (cmd_arg),
        .pend_i      (pend),
        .size_i      (size),
        .rbuf_data_i (rbuf_data),
        .cmd_ready_o (cmd_ready),
        .idle_o      (idle),
        .mask_ld_o   (mask_ld),
        .mask_val_o  (mask_val),
        .clr_bits_o  (clr_bits),
        .clr_size_o  (clr_size),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data),
        .rsp_last_o  (rsp_last),
        .rbuf_addr_o (rbuf_addr)
    );

endmodule

// File: tb/evt_irq_hub_test.sv
`timescale 1ns/1ps
module evt_irq_hub_test;
    localparam int T = 97;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_op = 1'b0;
    logic [3:0] cmd_argc = '0;
    logic [7:0] cmd_arg = '0;
    logic       cmd_ready;
    logic       dev_reply_valid = 1'b0;
    logic [3:0] dev_reply_len = '0;
    logic       poll_valid = 1'b0;
    logic [3:0] poll_len = '0;
    logic [2:0] rbuf_addr;
    logic [7:0] rbuf_data;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       rsp_last;
    logic       irq_n;

    logic [7:0] tb_buf [8];
    assign rbuf_data = tb_buf[rbuf_addr];

    always #2.5 clk = ~clk;

    evt_irq_hub #(.TICK_CYCLES(T)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_argc(cmd_argc), .cmd_arg(cmd_arg),
        .cmd_ready(cmd_ready),
        .dev_reply_valid(dev_reply_valid), .dev_reply_len(dev_reply_len),
        .poll_valid(poll_valid), .poll_len(poll_len),
        .rbuf_addr(rbuf_addr), .rbuf_data(rbuf_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .irq_n(irq_n)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] m_pend, m_mask, clr, sets;
    int         m_size, nsize, m_beats, m_tcnt, cyc;
    bit         idle_now, tick_now;
    string      cur_tag = "";
    logic [7:0] exp_d[$];
    string      exp_t[$];

    function automatic string tag_or(string dflt);
        return (cur_tag != "") ? cur_tag : dflt;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 8'h00; m_mask = 8'h30; m_size = 0; m_beats = 0;
            m_tcnt = 0; cyc = 0;
            exp_d.delete(); exp_t.delete();
        end else begin
            cyc++;
            idle_now = (m_beats == 0);
            tick_now = (m_tcnt == T - 1);
            m_tcnt   = tick_now ? 0 : m_tcnt + 1;
            if (m_beats != 0) m_beats--;
            clr = 8'h00; sets = 8'h00; nsize = m_size;
            if (idle_now && cmd_valid) begin
                if (cmd_op == 1'b0 && cmd_argc == 4'd1) begin
                    m_mask = cmd_arg;
                end else if (cmd_op == 1'b1 && cmd_argc == 4'd0) begin
                    if (m_pend[4]) begin
                        exp_d.push_back(m_pend & 8'h90); exp_t.push_back(tag_or("R6"));
                        for (int i = 0; i < m_size; i++) begin
                            exp_d.push_back(tb_buf[i]); exp_t.push_back(tag_or("R6"));
                        end
                        m_beats = 1 + m_size; clr = 8'h90; nsize = 0;
                    end else begin
                        exp_d.push_back(m_pend); exp_t.push_back(tag_or("R7"));
                        m_beats = 1; clr = 8'hFF;
                    end
                end
            end
            if (tick_now) sets |= 8'h20;
            if (idle_now && dev_reply_valid) begin
                sets |= 8'h10; nsize = int'(dev_reply_len);
            end else if (idle_now && poll_valid && !m_pend[4] && poll_len != 0) begin
                sets |= 8'h90; nsize = int'(poll_len);
            end
            m_pend = (m_pend & ~clr) | sets;
            m_size = nsize;
        end
    end

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 irq level", int'(irq_n), int'(~|(m_pend & m_mask)));
            chk("R10 ready", int'(cmd_ready), int'(m_beats == 0));
            chk("R5 reply presence", int'(rsp_valid), int'(m_beats != 0));
            if (rsp_valid && exp_d.size() != 0) begin
                logic [7:0] d;
                string t;
                d = exp_d.pop_front();
                t = exp_t.pop_front();
                chk({t, " data"}, int'(rsp_data), int'(d));
                chk({t, " last"}, int'(rsp_last), int'(exp_d.size() == 0));
            end
        end
    end

    // ---------------- stimulus helpers (called just after a posedge) ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_idle();
        while (m_beats != 0) step();
    endtask

    task automatic send_cmd(bit op, int argc, logic [7:0] arg);
        wait_idle();
        cmd_valid = 1'b1; cmd_op = op; cmd_argc = 4'(argc); cmd_arg = arg;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic send_reply(bit is_poll, int len, logic [7:0] base);
        wait_idle();
        if (!is_poll || (!m_pend[4] && len != 0))
            for (int i = 0; i < 8; i++) tb_buf[i] = base + 8'(i);
        if (is_poll) begin poll_valid = 1'b1; poll_len = 4'(len); end
        else begin dev_reply_valid = 1'b1; dev_reply_len = 4'(len); end
        step();
        poll_valid = 1'b0; dev_reply_valid = 1'b0;
    endtask

    task automatic wait_irq();
        while (irq_n) step();
    endtask

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", wd);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 8; i++) tb_buf[i] = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        chk("R2 irq after reset", int'(irq_n), 1);
        chk("R2 ready after reset", int'(cmd_ready), 1);
        cur_tag = "R2";
        send_cmd(1'b1, 0, 8'h00);          // reply 0x00

        cur_tag = "R3";
        wait_idle(); wait_irq();
        chk("R3 first tick phase", cyc % T, 0);
        send_cmd(1'b1, 0, 8'h00);          // reply 0x20
        wait_idle(); wait_irq();
        chk("R3 second tick phase", cyc % T, 0);

        cur_tag = "R4";
        send_cmd(1'b0, 2, 8'h00);
        chk("R4 bad argc keeps mask", int'(irq_n), 0);
        send_cmd(1'b0, 1, 8'h00);
        chk("R4 mask cleared", int'(irq_n), 1);
        send_cmd(1'b0, 1, 8'h20);
        chk("R4 mask tick", int'(irq_n), 0);

        cur_tag = "R5";
        send_cmd(1'b1, 2, 8'h00);
        chk("R5 no reply on bad argc", int'(rsp_valid), 0);
        chk("R5 pending kept", int'(irq_n), 0);
        send_cmd(1'b0, 1, 8'h30);

        cur_tag = "R7";
        send_cmd(1'b1, 0, 8'h00);
        wait_idle();
        chk("R7 all cleared", int'(irq_n), 1);

        cur_tag = "R9";
        send_reply(1'b0, 3, 8'hA1);
        chk("R9 device flag raises irq", int'(irq_n), 0);
        send_cmd(1'b1, 0, 8'h00);

        cur_tag = "R8";
        send_reply(1'b1, 2, 8'h51);
        send_cmd(1'b1, 0, 8'h00);          // 0x90, 51, 52
        send_reply(1'b0, 1, 8'h61);
        send_reply(1'b1, 4, 8'h71);        // rejected: device flag pending
        send_cmd(1'b1, 0, 8'h00);          // 0x10, 61
        send_reply(1'b1, 0, 8'h00);        // zero length: ignored
        send_cmd(1'b1, 0, 8'h00);          // single byte, non-device path

        cur_tag = "R10";
        wait_idle();
        while (m_tcnt != T - 1) step();
        send_cmd(1'b1, 0, 8'h00);          // accepted on the tick edge
        chk("R10 tick survives ack clear", int'(irq_n), 0);
        send_reply(1'b0, 3, 8'h81);
        send_cmd(1'b1, 0, 8'h00);          // device reply streaming
        dev_reply_valid = 1'b1; dev_reply_len = 4'd2;
        step();
        dev_reply_valid = 1'b0;
        chk("R10 busy ready low", int'(cmd_ready), 0);
        wait_idle();
        send_cmd(1'b1, 0, 8'h00);          // no device flag left
        wait_idle();

        cur_tag = "";
        for (int n = 0; n < 4000; n++) begin
            bit          dv, pv;
            logic [3:0]  dl, pl;
            dv = ($urandom % 16) == 0;
            pv = ($urandom % 6) == 0;
            dl = 4'($urandom % 9);
            pl = 4'($urandom % 9);
            cmd_valid = ($urandom % 4) == 0;
            cmd_op    = 1'($urandom);
            cmd_argc  = (($urandom % 8) == 0) ? 4'($urandom % 3) : (cmd_op ? 4'd0 : 4'd1);
            cmd_arg   = 8'($urandom);
            if (m_beats == 0 && (dv || (pv && !m_pend[4] && pl != 0)))
                for (int i = 0; i < 8; i++) tb_buf[i] = 8'($urandom);
            dev_reply_valid = dv; dev_reply_len = dl;
            poll_valid = pv; poll_len = pl;
            step();
        end
        cmd_valid = 1'b0; dev_reply_valid = 1'b0; poll_valid = 1'b0;
        wait_idle();
        repeat (4) step();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule